// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block turns a single multi-register memory transfer into a stream of word-sized accesses. A start pulse supplies a base address, a register-select mask, a walking mode and a base-update request. The block then presents one access per handshake. Each access carries a byte address, the index of the register it belongs to, and a flag that marks the program-counter slot. When the last access has been accepted, it raises a done pulse together with the updated base value, provided the update is allowed.

Two walking modes are supported. In increment-after mode the first access uses the base itself. In decrement-before mode the block subtracts the whole span (word size times the number of selected registers) from the base before the first access. In both modes the mask is then walked from its lowest bit upward and the address rises by one word per access. The lowest-numbered register therefore always lands at the lowest address. In decrement-before mode the base address is never touched, and the highest address used is one word below it.

The register file, the memory, data movement and any other addressing scheme belong to neighbouring logic.

Top module: `blk_xfer_seq`

## Requirements
- R1: A synchronous active-low reset returns the block to idle with `xfer_valid`, `seq_done` and `wb_valid` all low, including when the reset arrives in the middle of a sequence.
- R2: In increment-after mode (`mode_db` = 0) the first access address equals `base_addr`.
- R3: Exactly one access is issued per set mask bit, in ascending bit order. `xfer_idx` equals the bit position, and each following access address is the previous one plus 4 (modulo 2^ADDR_W).
- R4: In decrement-before mode (`mode_db` = 1) the first access address is `base_addr` minus 4 times the number of set mask bits. The last access address is `base_addr` minus 4.
- R5: The top mask bit (index NREG-1, the program counter) is handled as the final access with `xfer_pc` = 1. `xfer_pc` is 0 on every other access.
- R6: With the done pulse, `wb_valid` is 1 exactly when `wb_en` was 1 and the mask bit at `base_idx` was 0. When `wb_valid` is 1, `wb_value` is `base_addr` plus 4 times the count in increment-after mode, or minus 4 times the count in decrement-before mode.
- R7: While `xfer_valid` is 1 and `xfer_ready` is 0, `xfer_valid`, `xfer_addr`, `xfer_idx` and `xfer_pc` hold their values. The block advances only on a cycle where both are 1, so at most one access completes per cycle.
- R8: `seq_done` is a one-cycle pulse in the cycle after the last accepted access, with `xfer_valid` low. With an empty mask there is no access, `seq_done` rises in the cycle after start, and `wb_value` equals `base_addr`.
- R9: Start inputs are captured at the start pulse. Changes to `base_addr`, `reg_mask`, `mode_db`, `wb_en` or `base_idx` during a sequence have no effect, and a start pulse while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| base_addr | input | ADDR_W | Base byte address |
| reg_mask | input | NREG | Register-select mask, bit i selects register i |
| mode_db | input | 1 | 0 = increment-after, 1 = decrement-before |
| wb_en | input | 1 | Request a base update at the end |
| base_idx | input | $clog2(NREG) | Index of the base register |
| xfer_ready | input | 1 | Consumer accepts the current access |
| xfer_valid | output | 1 | An access is presented |
| xfer_addr | output | ADDR_W | Byte address of the access |
| xfer_idx | output | $clog2(NREG) | Register index of the access |
| xfer_pc | output | 1 | Access belongs to the program-counter slot |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |
| wb_valid | output | 1 | Base update permitted, qualified by `seq_done` |
| wb_value | output | ADDR_W | Updated base value |

## Verification
The bench builds the block with NREG = 8 and ADDR_W = 16. At that size every one of the 256 masks can be run in both modes within a short run, so the empty mask, the full mask, the program-counter slot alone and every base-in-list case are each reached. The narrow address also lets a small base wrap below zero in decrement-before mode, which checks the modular arithmetic. Handshake stalls, input disturbance and repeated start pulses are mixed in according to the mask value, so holding and input capture are tested across the whole sweep.

// File: rtl/blk_xfer_pkg.sv
// Shared types for the block-transfer address sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package blk_xfer_pkg;

    // Direction of the address walk selected at start.
    typedef enum logic {
        WALK_UP_AFTER   = 1'b0,
        WALK_DOWN_FIRST = 1'b1
    } walk_mode_e;

    // Sequencer control state.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/blk_xfer_popcount.sv
// Counts the set bits of a vector, combinationally.
// Assumes: W >= 1; the output is wide enough to hold W.
module blk_xfer_popcount #(
    parameter int W    = 16,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec,
    output logic [CNT_W-1:0] cnt
);

    // Sum every bit of the vector.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CNT_W'(vec[i]);
        end
    end

endmodule

// File: rtl/blk_xfer_lowest.sv
// Finds the lowest set bit of a vector, and reports whether it is the only one.
// Assumes: W >= 2; idx is meaningless when any is low.
module blk_xfer_lowest #(
    parameter int W    = 16,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             any,
    output logic             single
);

    // Priority scan from the top down so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

    // Presence and uniqueness of the set bit.
    always_comb begin
        any    = |vec;
        single = any && ((vec & (vec - W'(1))) == '0);
    end

endmodule

// File: rtl/blk_xfer_seq.sv
// Block-transfer address sequencer: walks a register mask from its lowest bit
// upward and issues one word access per set bit under a valid/ready handshake,
// then pulses done with an optional base-update value.
// Assumes: addresses wrap modulo 2^ADDR_W; the top mask bit is the program
// counter; start is only taken while idle.
module blk_xfer_seq
    import blk_xfer_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W  = $clog2(NREG),
    localparam int CNT_W  = $clog2(NREG + 1),
    localparam int PC_IDX = NREG - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [NREG-1:0]   reg_mask,
    input  logic              mode_db,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic              xfer_ready,
    output logic              xfer_valid,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [IDX_W-1:0]  xfer_idx,
    output logic              xfer_pc,
    output logic              seq_done,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_value
);

    seq_state_e        state_q;
    logic [NREG-1:0]   rem_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] wbv_q;
    logic              wb_ok_q;
    logic              done_q;
    logic              wbvalid_q;

    logic [CNT_W-1:0]  sel_cnt;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] low_end;
    logic [ADDR_W-1:0] high_end;
    walk_mode_e        start_mode;
    logic              start_wb_ok;
    logic [IDX_W-1:0]  cur_idx;
    logic              cur_any;
    logic              cur_single;
    logic              take;
    logic              accept;

    blk_xfer_popcount #(.W(NREG)) u_count (
        .vec (reg_mask),
        .cnt (sel_cnt)
    );

    blk_xfer_lowest #(.W(NREG)) u_pick (
        .vec    (rem_q),
        .idx    (cur_idx),
        .any    (cur_any),
        .single (cur_single)
    );

    // Start-time arithmetic: byte span, both end points and the update permission.
    always_comb begin
        start_mode  = mode_db ? WALK_DOWN_FIRST : WALK_UP_AFTER;
        span        = ADDR_W'(sel_cnt) * ADDR_W'(WORD_BYTES);
        low_end     = base_addr - span;
        high_end    = base_addr + span;
        start_wb_ok = wb_en && !reg_mask[base_idx];
        take        = (state_q == SEQ_IDLE) && start;
        accept      = (state_q == SEQ_RUN) && xfer_ready;
    end

    // Control state, remaining mask, running address and end-of-sequence pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            rem_q     <= '0;
            addr_q    <= '0;
            wbv_q     <= '0;
            wb_ok_q   <= 1'b0;
            done_q    <= 1'b0;
            wbvalid_q <= 1'b0;
        end else begin
            done_q    <= 1'b0;
            wbvalid_q <= 1'b0;
            if (take) begin
                rem_q   <= reg_mask;
                addr_q  <= (start_mode == WALK_DOWN_FIRST) ? low_end : base_addr;
                wbv_q   <= (start_mode == WALK_DOWN_FIRST) ? low_end : high_end;
                wb_ok_q <= start_wb_ok;
                if (reg_mask == '0) begin
                    done_q    <= 1'b1;
                    wbvalid_q <= start_wb_ok;
                end else begin
                    state_q <= SEQ_RUN;
                end
            end else if (accept) begin
                rem_q  <= rem_q & ~(NREG'(1) << cur_idx);
                addr_q <= addr_q + ADDR_W'(WORD_BYTES);
                if (cur_single) begin
                    state_q   <= SEQ_IDLE;
                    done_q    <= 1'b1;
                    wbvalid_q <= wb_ok_q;
                end
            end
        end
    end

    // Output mapping.
    always_comb begin
        xfer_valid = (state_q == SEQ_RUN);
        xfer_addr  = addr_q;
        xfer_idx   = cur_idx;
        xfer_pc    = xfer_valid && (cur_idx == IDX_W'(PC_IDX));
        seq_done   = done_q;
        wb_valid   = wbvalid_q;
        wb_value   = wbv_q;
    end

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_idx) && $stable(xfer_pc)); // R7
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && xfer_ready && !cur_single |=> xfer_valid && (xfer_addr == $past(xfer_addr) + ADDR_W'(WORD_BYTES))); // R3
    AST_IDX_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && xfer_ready && !cur_single |=> xfer_idx > $past(xfer_idx)); // R3
    AST_VALID_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> cur_any); // R3
    AST_PC_IS_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && xfer_pc |-> cur_single); // R5
    AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> seq_done); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> !xfer_valid); // R8
    AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_valid && start && (reg_mask == '0) |=> seq_done && !xfer_valid); // R8
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && !xfer_ready && start |=> xfer_valid && $stable(xfer_addr)); // R9

endmodule

// File: tb/blk_xfer_seq_test.sv
// Exhaustive mask sweep of the sequencer at NREG = 8, ADDR_W = 16.
module blk_xfer_seq_test;

    localparam int AW = 16;
    localparam int NR = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [NR-1:0] reg_mask = '0;
    logic          mode_db = 1'b0;
    logic          wb_en = 1'b0;
    logic [IW-1:0] base_idx = '0;
    logic          xfer_ready = 1'b0;
    logic          xfer_valid;
    logic [AW-1:0] xfer_addr;
    logic [IW-1:0] xfer_idx;
    logic          xfer_pc;
    logic          seq_done;
    logic          wb_valid;
    logic [AW-1:0] wb_value;

    int  checks = 0;
    int  failures = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    blk_xfer_seq #(.ADDR_W(AW), .NREG(NR), .WORD_BYTES(4)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .reg_mask(reg_mask), .mode_db(mode_db), .wb_en(wb_en), .base_idx(base_idx),
        .xfer_ready(xfer_ready), .xfer_valid(xfer_valid), .xfer_addr(xfer_addr),
        .xfer_idx(xfer_idx), .xfer_pc(xfer_pc), .seq_done(seq_done),
        .wb_valid(wb_valid), .wb_value(wb_value)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One full sequence; stall > 0 drops ready every stall-th presented cycle.
    task automatic run(input logic [NR-1:0] m, input bit db, input logic [AW-1:0] base,
                       input bit we, input logic [IW-1:0] bi, input int stall, input bit disturb);
        int            cnt;
        int            k;
        bit            first;
        logic [AW-1:0] a;
        logic [AW-1:0] last_a;
        logic [AW-1:0] wexp;
        bit            wok;
        cnt    = $countones(m);
        a      = db ? base - AW'(4 * cnt) : base;
        wexp   = db ? base - AW'(4 * cnt) : base + AW'(4 * cnt);
        wok    = we && !m[bi];
        first  = 1'b1;
        last_a = a;
        k      = 0;
        @(negedge clk);
        start = 1'b1; base_addr = base; reg_mask = m; mode_db = db;
        wb_en = we; base_idx = bi; xfer_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            base_addr = ~base; reg_mask = ~m; mode_db = ~db; wb_en = ~we; base_idx = bi + 3'd1;
        end
        for (int i = 0; i < NR; i++) begin
            if (m[i]) begin
                while (1) begin
                    chk(xfer_valid == 1'b1, "R3 valid", xfer_valid, 1);
                    chk(xfer_addr == a, first ? (db ? "R4 first addr" : "R2 first addr") : "R3 addr", xfer_addr, a);
                    chk(xfer_idx == IW'(i), "R3 idx", xfer_idx, i);
                    chk(xfer_pc == (i == NR - 1), "R5 pc flag", xfer_pc, (i == NR - 1));
                    k++;
                    if (stall != 0 && (k % stall) == 0) begin
                        xfer_ready = 1'b0;
                        if (disturb) start = 1'b1;   // R9: ignored while busy
                        @(negedge clk);
                        start = 1'b0;
                    end else begin
                        xfer_ready = 1'b1;
                        @(negedge clk);
                        xfer_ready = 1'b0;
                        break;
                    end
                end
                last_a = a;
                a      = a + AW'(4);
                first  = 1'b0;
            end
        end
        if (db && cnt > 0) chk(last_a == base - AW'(4), "R4 last addr", last_a, base - AW'(4));
        chk(seq_done == 1'b1, "R8 done", seq_done, 1);
        chk(xfer_valid == 1'b0, "R8 valid low at done", xfer_valid, 0);
        chk(wb_valid == wok, "R6 wb_valid", wb_valid, wok);
        if (wok) chk(wb_value == wexp, "R6 wb_value", wb_value, wexp);
        if (cnt == 0) chk(wb_value == base, "R8 empty wb_value", wb_value, base);
        start = 1'b0;
        @(negedge clk);
        chk(seq_done == 1'b0, "R8 done pulse", seq_done, 0);
        chk(xfer_valid == 1'b0, "R9 no restart", xfer_valid, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(xfer_valid == 1'b0, "R1 valid in reset", xfer_valid, 0);
        chk(seq_done == 1'b0, "R1 done in reset", seq_done, 0);
        chk(wb_valid == 1'b0, "R1 wb in reset", wb_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(xfer_valid == 1'b0, "R1 idle after reset", xfer_valid, 0);

        // Worked example: r1, r2 in decrement-before from 0x1000.
        run(8'b0000_0110, 1'b1, 16'h1000, 1'b1, 3'd5, 0, 1'b0);

        // Exhaustive sweep over masks and modes.
        for (int m = 0; m < 256; m++) begin
            for (int d = 0; d < 2; d++) begin
                run(NR'(m), d[0], 16'h1000 + AW'(m * 16), (m % 3) != 0, IW'(m + d),
                    (m % 4 == 0) ? 0 : (m % 3) + 2, m[1] ^ d[0]);
            end
        end

        // Decrement-before wrapping below zero.
        run(8'hFF, 1'b1, 16'h0008, 1'b1, 3'd0, 2, 1'b1);
        run(8'h81, 1'b1, 16'h0004, 1'b1, 3'd3, 0, 1'b0);

        // Reset in the middle of a sequence.
        @(negedge clk);
        start = 1'b1; reg_mask = 8'hFF; base_addr = 16'h2000; mode_db = 1'b0;
        @(negedge clk);
        start = 1'b0; xfer_ready = 1'b1;
        @(negedge clk);
        xfer_ready = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk(xfer_valid == 1'b0, "R1 mid reset valid", xfer_valid, 0);
        chk(seq_done == 1'b0, "R1 mid reset done", seq_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(xfer_valid == 1'b0, "R1 stays idle", xfer_valid, 0);
        run(8'h0C, 1'b0, 16'h3000, 1'b1, 3'd2, 0, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule